// File: doc/BRIEF.md
# Stallable Fixed-Latency Delay Line

This block holds back a stream of data words by a fixed number of clock cycles, set when the design is elaborated. It is meant for balancing pipeline branches: a word captured on one edge comes out a known number of edges later. The whole line can be paused with a clock-enable input. While paused, no word moves and the output does not change.

Inside, the line is a cascade of 16-entry shift-register segments. Each segment has a constant 4-bit tap address, and a segment delays by its tap address plus one. Every segment except the last is tapped at its deepest entry, and the last is tapped wherever the remaining delay requires. A delay of zero builds no storage at all and wires the input straight to the output.

A synchronous reset affects only what the output shows. The stored words are never cleared, so words in flight at reset come out later.

Top module: `stall_delay_line`

## Requirements
- R1: For a delay of N greater than 0, a word captured on a rising edge where clk_en is 1 appears on data_out right after the N-th enabled edge, counting its own capture edge. Edges where clk_en is 0 are not counted.
- R2: While clk_en is 0 and rst is 0, no stored word moves and data_out keeps its value across the edge.
- R3: With DELAY = 0, data_out equals data_in in the same cycle, whatever clk_en and rst are doing.
- R4: For DELAY greater than 0, rst (active high, synchronous) makes data_out 0 from the edge where rst is sampled high. data_out stays 0 until the first edge where rst is 0 and clk_en is 1.
- R5: Reset never clears the stored words. The line keeps shifting on enabled edges even while rst is high, and words captured before or during a reset come out at their normal positions once the output is shown again.
- R6: The line uses ceil(N/16) segments. Every segment except the last has tap address 15 (16 cycles). The last has tap address N - 16*(ceil(N/16)-1) - 1. So delays of 16, 17 and 35 each give exactly N cycles of latency.
- R7: The data width DATA_W may be any value from 1 to 64, and input and output have the same width. Every bit travels with the same latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; blanks the output only |
| clk_en | input | 1 | 1 shifts the line on this edge, 0 freezes it |
| data_in | input | DATA_W | Word entering the line |
| data_out | output | DATA_W | Word leaving the line, DELAY enabled edges later |

## Verification
The hardest case to reach from the ports is a reset that lands while the line is full of known words. The output must then stay blank through the reset and through any stalled cycles after it, and the old words must reappear afterwards. The bench first fills every instance with known words, some of them during reset with shifting enabled. It then pulses reset with the line both frozen and shifting, and holds clk_en low after release before streaming again. Delays of 16 and 17 sit on either side of a segment boundary and run beside 0, 1 and 35, all under random stalls.

// File: rtl/stall_delay_line_pkg.sv
package stall_delay_line_pkg;

  localparam int SEG_DEPTH  = 16;
  localparam int SEG_ADDR_W = $clog2(SEG_DEPTH);

  // Strobes passed from control to datapath
  typedef struct packed {
    logic shiftEn;  // advance every segment on this edge
    logic maskOut;  // show zero instead of the tap
  } lineCtrl_t;

  function automatic int segCount(input int delayCyc);
    return (delayCyc + SEG_DEPTH - 1) / SEG_DEPTH;
  endfunction

  // Tap address for segment idx of a line of delayCyc cycles
  function automatic int segTap(input int delayCyc, input int idx);
    if (idx < segCount(delayCyc) - 1)
      return SEG_DEPTH - 1;
    return delayCyc - SEG_DEPTH * (segCount(delayCyc) - 1) - 1;
  endfunction

endpackage

// File: rtl/sdl_segment.sv
module sdl_segment
  import stall_delay_line_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TAP    = SEG_DEPTH - 1
) (
  input  logic              clk,
  input  logic              shiftEn,
  input  logic [DATA_W-1:0] segIn,
  output logic [DATA_W-1:0] segOut
);

  localparam logic [SEG_ADDR_W-1:0] TAP_ADDR = SEG_ADDR_W'(TAP);

  // Storage is intentionally never reset (R5)
  logic [DATA_W-1:0] stageMem [SEG_DEPTH];

  always_ff @(posedge clk) begin
    if (shiftEn) begin
      stageMem[0] <= segIn;
      for (int i = 1; i < SEG_DEPTH; i++)
        stageMem[i] <= stageMem[i-1];
    end
  end

  // Entry TAP holds the word written TAP+1 enabled edges ago
  assign segOut = stageMem[TAP_ADDR];

endmodule

// File: rtl/sdl_ctrl.sv
module sdl_ctrl
  import stall_delay_line_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      clkEn,
  output lineCtrl_t ctrl
);

  logic blankQ;

  // Output stays blank from reset until the first enabled edge after it
  always_ff @(posedge clk) begin
    if (rst)
      blankQ <= 1'b1;
    else if (clkEn)
      blankQ <= 1'b0;
  end

  always_comb begin
    ctrl.shiftEn = clkEn;
    ctrl.maskOut = blankQ;
  end

endmodule

// File: rtl/sdl_datapath.sv
module sdl_datapath
  import stall_delay_line_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DELAY  = 35
) (
  input  logic              clk,
  input  lineCtrl_t         ctrl,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut
);

  localparam int NUM_SEG = segCount(DELAY);

  generate
    if (DELAY == 0) begin : g_wire
      assign dataOut = dataIn;
    end else begin : g_chain
      logic [DATA_W-1:0] link [NUM_SEG+1];
      assign link[0] = dataIn;

      for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        sdl_segment #(
          .DATA_W (DATA_W),
          .TAP    (segTap(DELAY, g))
        ) u_seg (
          .clk     (clk),
          .shiftEn (ctrl.shiftEn),
          .segIn   (link[g]),
          .segOut  (link[g+1])
        );
      end

      assign dataOut = ctrl.maskOut ? '0 : link[NUM_SEG];
    end
  endgenerate

endmodule

// File: rtl/stall_delay_line.sv
module stall_delay_line
  import stall_delay_line_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DELAY  = 35
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out
);

  lineCtrl_t lineCtrl;

  sdl_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .clkEn (clk_en),
    .ctrl  (lineCtrl)
  );

  sdl_datapath #(
    .DATA_W (DATA_W),
    .DELAY  (DELAY)
  ) u_dp (
    .clk     (clk),
    .ctrl    (lineCtrl),
    .dataIn  (data_in),
    .dataOut (data_out)
  );

endmodule

// File: rtl/stall_delay_line_chk.sv
module stall_delay_line_chk #(
  parameter int DATA_W = 16,
  parameter int DELAY  = 35
) (
  input logic              clk,
  input logic              rst,
  input logic              clk_en,
  input logic [DATA_W-1:0] data_in,
  input logic [DATA_W-1:0] data_out
);

  generate
    if (DELAY == 0) begin : g_zero
      assert_passthrough_R3: assert property (@(posedge clk) disable iff (rst)
        data_out == data_in);
    end else begin : g_line
      assert_stall_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> $stable(data_out));
      assert_reset_blank_R4: assert property (@(posedge clk)
        rst |=> data_out == '0);
      if (DELAY == 1) begin : g_one
        assert_single_stage_R1: assert property (@(posedge clk) disable iff (rst)
          clk_en |=> data_out == $past(data_in));
      end
    end
  endgenerate

endmodule

bind stall_delay_line stall_delay_line_chk #(
  .DATA_W (DATA_W),
  .DELAY  (DELAY)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .clk_en   (clk_en),
  .data_in  (data_in),
  .data_out (data_out)
);

// File: tb/stall_delay_line_bench.sv
`timescale 1ns/1ps
module stall_delay_line_bench;

  localparam real CLK_PER = 20.0;  // 50 MHz
  localparam int  W = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clkEn = 1'b0;
  logic [W-1:0] dataIn = '0;
  logic [W-1:0] out35, out0, out1, out16, out17;
  logic [0:0]   outW1;

  always #(CLK_PER/2) clk = ~clk;

  stall_delay_line #(.DATA_W(W), .DELAY(35)) u_stall_delay_line (
    .clk(clk), .rst(rst), .clk_en(clkEn), .data_in(dataIn), .data_out(out35));
  stall_delay_line #(.DATA_W(W), .DELAY(0)) u_stall_delay_line_d0 (
    .clk(clk), .rst(rst), .clk_en(clkEn), .data_in(dataIn), .data_out(out0));
  stall_delay_line #(.DATA_W(W), .DELAY(1)) u_stall_delay_line_d1 (
    .clk(clk), .rst(rst), .clk_en(clkEn), .data_in(dataIn), .data_out(out1));
  stall_delay_line #(.DATA_W(W), .DELAY(16)) u_stall_delay_line_d16 (
    .clk(clk), .rst(rst), .clk_en(clkEn), .data_in(dataIn), .data_out(out16));
  stall_delay_line #(.DATA_W(W), .DELAY(17)) u_stall_delay_line_d17 (
    .clk(clk), .rst(rst), .clk_en(clkEn), .data_in(dataIn), .data_out(out17));
  stall_delay_line #(.DATA_W(1), .DELAY(17)) u_stall_delay_line_w1 (
    .clk(clk), .rst(rst), .clk_en(clkEn), .data_in(dataIn[0:0]), .data_out(outW1));

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // Reference model: every word captured on an enabled edge
  logic [W-1:0] hist [4096];
  int  histCnt = 0;
  bit  blankM  = 1'b1;

  function automatic logic [W-1:0] expOut(input int n);
    if (blankM) return '0;
    return hist[histCnt - n];
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One cycle: drive after negedge, model the edge, check before next drive
  task automatic tick(input bit en, input logic [W-1:0] d, input bit r, input string tag);
    logic [W-1:0] p35, p1, p16, p17;
    p35 = out35; p1 = out1; p16 = out16; p17 = out17;
    clkEn = en; dataIn = d; rst = r;
    #1;
    chk("R3", "zero delay follows input", out0, dataIn);
    @(posedge clk);
    if (en) begin
      hist[histCnt] = d;
      histCnt++;
    end
    if (r) blankM = 1'b1;
    else if (en) blankM = 1'b0;
    @(negedge clk);
    chk(tag, "delay 1",  out1,  expOut(1));
    chk(tag, "delay 16", out16, expOut(16));
    chk(tag, "delay 17", out17, expOut(17));
    chk(tag, "delay 35", out35, expOut(35));
    chk("R7", "1-bit delay 17", {63'd0, outW1}, {63'd0, expOut(17) & 64'd1});
    if (!en && !r) begin
      chk("R2", "stall hold d1",  out1,  p1);
      chk("R2", "stall hold d16", out16, p16);
      chk("R2", "stall hold d17", out17, p17);
      chk("R2", "stall hold d35", out35, p35);
    end
  endtask

  // R4: fill every line during reset, output must stay 0
  task automatic t_fill_in_reset();
    for (int i = 0; i < 40; i++)
      tick(1'b1, {32'hF111_0000 + i, 32'h0F0F_0000 + i}, 1'b1, "R4");
    chk("R4", "blank after fill", out35, '0);
  endtask

  // R1: continuous stream, distinct words
  task automatic t_stream();
    for (int i = 0; i < 60; i++)
      tick(1'b1, {16'hC0DE, 16'(i), 32'h8000_0001 ^ (32'(i) << 7)}, 1'b0, "R1");
  endtask

  // R6: segment boundaries 16/17/35 under alternating enable
  task automatic t_boundary();
    for (int i = 0; i < 80; i++)
      tick((i % 3) != 2, {32'hB0B0_0000 + i, ~(32'(i) * 32'h9E37)}, 1'b0, "R6");
  endtask

  // R2: random stalls and a long freeze
  task automatic t_random_stalls();
    for (int i = 0; i < 200; i++)
      tick(($urandom % 4) != 0, {$urandom, $urandom}, 1'b0, "R2");
    for (int i = 0; i < 20; i++)
      tick(1'b0, {$urandom, $urandom}, 1'b0, "R2");
  endtask

  // R4/R5: reset while frozen, reset while shifting, release while frozen
  task automatic t_reset_inflight();
    for (int i = 0; i < 10; i++)
      tick(1'b1, {32'h5EED_0000 + i, 32'hAAAA_5555}, 1'b0, "R5");
    for (int i = 0; i < 3; i++)
      tick(1'b0, 64'hDEAD_BEEF_DEAD_BEEF, 1'b1, "R4");
    for (int i = 0; i < 2; i++)
      tick(1'b1, {32'h1234_0000 + i, 32'h4321_0000}, 1'b1, "R5");
    for (int i = 0; i < 3; i++)
      tick(1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R4");
    chk("R4", "blank until enabled edge", out17, '0);
    for (int i = 0; i < 45; i++)
      tick(($urandom % 5) != 0, {$urandom, $urandom}, 1'b0, "R5");
  endtask

  initial begin
    @(negedge clk);
    chk("R4", "reset state d35", out35, '0);
    t_fill_in_reset();
    t_stream();
    t_boundary();
    t_random_stalls();
    t_reset_inflight();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PER * 200000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule